// File: doc/BRIEF.md
# Parallel Test Mode DRAM Core

This block is a device-side model of a multiplexed-address DRAM with a compressed test mode. It samples the row strobe, column strobe and write strobe on every rising clock edge and classifies each row-strobe cycle. A row cycle latches the row from the shared address bus. A column-strobe fall inside that cycle then reads or writes one word of a small parameterised cell array.

A strobe ordering in which the column and write strobes are both already low when the row strobe falls sets a mode latch. While the latch is set, the array behaves as if each data pin were four cells wide. The two lowest column bits are ignored. A write copies each pin's bit into the matching bit of the four words that share the upper column bits. A read returns, per pin, a flag that is high only when those four cells agree. Two cycles clear the latch: a column-before-row cycle with the write strobe high, and a row cycle that ends without any column strobe.

The strobe pins are plain levels with no handshake and no back-pressure. Read data appears on `rd_data` with a one-cycle `rd_valid` strobe, and it must be taken in that cycle.

Top module: `dram_parallel_test`

## Requirements
- R1: Outside test mode, a write at (row, column) stores the 4-bit `dq_in` word, and a later read at the same address returns that word on `rd_data`.
- R2: A row-strobe fall that samples `cas_n` = 0 and `we_n` = 0 sets `test_mode` to 1 from the next cycle. This holds whether or not the mode was already set.
- R3: A row-strobe fall that samples `cas_n` = 0 and `we_n` = 1 clears `test_mode`, and that cycle performs no array access.
- R4: A row cycle in which `cas_n` is high at the row-strobe fall and never falls before the row strobe rises clears `test_mode` at the row-strobe rise.
- R5: In test mode, a write to column c stores bit i of `dq_in` into bit i of all four words whose column equals c with its two lowest bits replaced by 0, 1, 2 and 3. Column bits [1:0] have no effect.
- R6: In test mode, bit i of the read result is 1 exactly when bit i is the same in all four words of the addressed group. Column bits [1:0] have no effect.
- R7: While test mode is set, the entry ordering of R2 serves as the refresh cycle and leaves `test_mode` at 1.
- R8: After reset, `test_mode` and `rd_valid` are 0. `test_mode` changes only on a clock edge at which the sampled `ras_n` differs from its previously sampled level.
- R9: A column access happens on the edge that first samples `cas_n` low while `ras_n` was already low on the edge before and the cycle is not column-before-row. If `we_n` is 1, `rd_valid` is 1 for exactly the following cycle. If `we_n` is 0, `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| rd_data | output | DQ_W | Read word, or per-pin agreement flags in test mode |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` valid |
| test_mode | output | 1 | State of the test mode latch |

## Verification
The hardest case to reach is a test-mode read over a group whose four cells disagree in only some bits. A test-mode write always makes the cells of a group identical, so such a group can only come from normal-mode writes. The stimulus first fills the array with an arithmetic pattern in normal mode and reads every group in test mode. It then leaves test mode through a row-only cycle, rewrites a single cell with selected bits flipped, and re-enters test mode before reading that group again. Expected flags come from a bench-side copy of the array contents.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/ptm_strobe_decode.sv
module ptm_strobe_decode
  import ptm_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ras_fall,
  output logic              ras_only_end,
  output acc_e              acc,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  logic             ras_q, cas_q, cbr_q, used_q;
  logic [ROW_W-1:0] row_q;
  logic             ras_rise, col_hit;

  always_comb begin
    ras_fall     = ras_q & ~ras_n;
    ras_rise     = ~ras_q & ras_n;
    col_hit      = ~ras_q & ~ras_n & cas_q & ~cas_n & ~cbr_q;
    ras_only_end = ras_rise & ~cbr_q & ~used_q;
    if (col_hit) acc = we_n ? ACC_READ : ACC_WRITE;
    else         acc = ACC_NONE;
    row = row_q;
    col = addr[COL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      cbr_q  <= 1'b0;
      used_q <= 1'b1;
      row_q  <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        row_q  <= addr[ROW_W-1:0];
        cbr_q  <= ~cas_n;
        used_q <= 1'b0;
      end else if (col_hit) begin
        used_q <= 1'b1;
      end
    end
  end

  // R9: a column access only ever happens inside a low row strobe
  p_access_in_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != ACC_NONE) |-> (!ras_n && $past(!ras_n)));
endmodule

// File: rtl/ptm_mode_latch.sv
module ptm_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_fall,
  input  logic ras_only_end,
  input  logic cas_n,
  input  logic we_n,
  output logic test_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   test_mode <= 1'b0;
    else if (ras_fall && !cas_n)  test_mode <= ~we_n;
    else if (ras_only_end)        test_mode <= 1'b0;
  end

  // R2 / R7: entry ordering sets or keeps the mode
  p_entry_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> test_mode);
  // R3: column-before-row with write high leaves the mode
  p_cbr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);
  // R4: row-only cycle end leaves the mode
  p_rasonly_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ras_only_end |=> !test_mode);
endmodule

// File: rtl/ptm_cell_array.sv
module ptm_cell_array
  import ptm_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int DQ_W     = 4,
  parameter int CMP_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_e             acc,
  input  logic             test_mode,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [DQ_W-1:0]  wdata,
  output logic [DQ_W-1:0]  rd_data,
  output logic             rd_valid
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int WORDS = 1 << IDX_W;
  localparam int GRP   = 1 << CMP_BITS;

  logic [DQ_W-1:0]  mem [WORDS];
  logic [IDX_W-1:0] word_idx, base_idx;
  logic [DQ_W-1:0]  grp [GRP];
  logic [DQ_W-1:0]  agree;

  assign word_idx = {row, col};
  assign base_idx = {row, col[COL_W-1:CMP_BITS], {CMP_BITS{1'b0}}};

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    assign grp[g] = mem[base_idx | IDX_W'(g)];
  end

  always_comb begin
    agree = '1;
    for (int g = 1; g < GRP; g++) agree &= ~(grp[g] ^ grp[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= (acc == ACC_READ);
      if (acc == ACC_READ) rd_data <= test_mode ? agree : mem[word_idx];
      if (acc == ACC_WRITE) begin
        if (test_mode) begin
          for (int g = 0; g < GRP; g++) mem[base_idx | IDX_W'(g)] <= wdata;
        end else begin
          mem[word_idx] <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/dram_parallel_test.sv
module dram_parallel_test
  import ptm_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int DQ_W     = 4,
  parameter int CMP_BITS = 2,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              test_mode
);
  logic             ras_fall, ras_only_end;
  acc_e             acc;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  ptm_strobe_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ras_fall(ras_fall), .ras_only_end(ras_only_end),
    .acc(acc), .row(row), .col(col)
  );

  ptm_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_only_end(ras_only_end),
    .cas_n(cas_n), .we_n(we_n), .test_mode(test_mode)
  );

  ptm_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .CMP_BITS(CMP_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .acc(acc), .test_mode(test_mode), .row(row),
    .col(col), .wdata(dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R8: the mode only moves when the row strobe changes level
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == $past(ras_n)) |=> $stable(test_mode));
  // R9: a read produces exactly one valid strobe
  p_read_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_READ) |=> rd_valid);
  // R9: a write never raises the read strobe
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_WRITE) |=> !rd_valid);
  // R9: no strobe without a preceding read
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != ACC_READ) |=> !rd_valid);
endmodule

// File: tb/dram_parallel_test_bench.sv
module dram_parallel_test_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0]    dq_in = '0;
  logic [3:0]    rd_data;
  logic          rd_valid, test_mode;
  logic [3:0]    model [64];
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_parallel_test u_dram_parallel_test (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .test_mode(test_mode)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input int r, input int c, input logic wr, input logic [3:0] d,
                        output logic [3:0] got, output logic v);
    @(negedge clk); ras_n = 1'b0; addr = AW'(r);
    @(negedge clk); cas_n = 1'b0; addr = AW'(c); we_n = ~wr; dq_in = d;
    @(negedge clk); got = rd_data; v = rd_valid;
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_word(input int r, input int c, input logic [3:0] d);
    logic [3:0] g; logic v;
    access(r, c, 1'b1, d, g, v);
    chk("R9 write strobe", {3'b0, v}, 4'h0);
  endtask

  task automatic rd_word(input string req, input int r, input int c, input logic [3:0] exp);
    logic [3:0] g; logic v;
    access(r, c, 1'b0, 4'h0, g, v);
    chk("R9 read strobe", {3'b0, v}, 4'h1);
    chk(req, g, exp);
  endtask

  task automatic cbr(input logic w);
    @(negedge clk); cas_n = 1'b0; we_n = w;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [3:0] grp_eq(input int r, input int g);
    logic [3:0] e = 4'hF;
    for (int k = 1; k < 4; k++) e &= ~(model[r*8 + g*4 + k] ^ model[r*8 + g*4]);
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset mode", {3'b0, test_mode}, 4'h0);
    chk("R8 reset valid", {3'b0, rd_valid}, 4'h0);

    // R1: normal sweep
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        model[r*8+c] = 4'((r*3 + c*5 + 1) & 15);
        wr_word(r, c, model[r*8+c]);
      end
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) rd_word("R1 normal read", r, c, model[r*8+c]);

    // R2: entry
    cbr(1'b0);
    chk("R2 entry", {3'b0, test_mode}, 4'h1);

    // R6: agreement flags over mixed contents
    for (int r = 0; r < 8; r++)
      for (int g = 0; g < 2; g++) rd_word("R6 compare mixed", r, g*4 + ((r+g) & 3), grp_eq(r, g));

    // R5: fan-out writes, R6 compare after them
    for (int r = 0; r < 8; r++)
      for (int g = 0; g < 2; g++) begin
        logic [3:0] d = 4'((r*5 + g*9 + 2) & 15);
        wr_word(r, g*4 + ((r*3) & 3), d);
        for (int k = 0; k < 4; k++) model[r*8 + g*4 + k] = d;
      end
    for (int r = 0; r < 8; r++)
      for (int g = 0; g < 2; g++) rd_word("R6 compare uniform", r, g*4 + ((r+1) & 3), 4'hF);

    // R7: entry ordering while in test mode keeps it
    cbr(1'b0);
    chk("R7 refresh in test", {3'b0, test_mode}, 4'h1);

    // R4: row-only cycle, R8 hold while row low
    @(negedge clk); ras_n = 1'b0; addr = AW'(2);
    @(negedge clk); @(negedge clk);
    chk("R8 hold during row", {3'b0, test_mode}, 4'h1);
    ras_n = 1'b1;
    @(negedge clk);
    chk("R4 row-only exit", {3'b0, test_mode}, 4'h0);

    // R5: each cell got its pin value
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) rd_word("R5 fan-out cells", r, c, model[r*8+c]);

    // R6: partial disagreement
    model[5*8+6] = model[5*8+6] ^ 4'b0101;
    wr_word(5, 6, model[5*8+6]);
    cbr(1'b0);
    chk("R2 re-entry", {3'b0, test_mode}, 4'h1);
    rd_word("R6 partial mismatch", 5, 4, grp_eq(5, 1));
    chk("R6 expected flags", grp_eq(5, 1), 4'b1010);

    // R3: exit via column-before-row, no access
    cbr(1'b1);
    chk("R3 cbr exit", {3'b0, test_mode}, 4'h0);
    chk("R3 no strobe", {3'b0, rd_valid}, 4'h0);
    rd_word("R3 array intact", 5, 6, model[5*8+6]);
    rd_word("R3 array intact", 5, 7, model[5*8+7]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule